// File: doc/BRIEF.md
# PLL output frequency decoder

This block works out the output frequency, in Hz, of one clock synthesiser from the register values that configure it. It receives a boot configuration word, the bit offset of that synthesiser's source-select field inside the boot word, the synthesiser's divider control word and its loop control word. It also receives four candidate input frequencies: bus, reference, crystal and CPU. From these it picks the input frequency, decodes the pre-divider, post-divider and multiplier, and selects one of four arithmetic paths. It then divides the resulting numerator by the total divisor.

A one-cycle `start` pulse samples every input. The block forms the numerator in the same cycle and hands it to a restoring shift-subtract divider that retires one quotient bit per clock. When the quotient is ready, `freq` is updated and `done` pulses for one cycle. `freq` then holds its value until the next result. Software uses the result to report or derive clock rates. This block does not program the synthesiser and does not search for divider settings.

Top module: `pll_freq_decoder`

## Requirements
- R1: The input frequency is chosen by the 2-bit field `(boot_word >> src_shift) & 3`: code 0 selects `base_bus`, 1 `base_ref`, 2 `base_xtal` and 3 `base_cpu`.
- R2: The divisor is (ctrl_word[20:16] + 1) × (ctrl_word[4:0] + 1), which ranges from 1 to 1024, and every path divides its numerator by it.
- R3: The multiplier is pll_word[15:12] + 1, which ranges from 1 to 16.
- R4: When boot_word[5] is 1, the result is base / divisor, whatever the loop control word holds.
- R5: Otherwise, when pll_word[0] is 0, the result is (base >> 1) / divisor for a multiplier below 16, and (base >> 2) / divisor for a multiplier of 16.
- R6: Otherwise, when pll_word[11] and pll_word[1] are both 1, the numerator is (base × mul) >> 1 for an odd multiplier and (base × (mul − 1)) >> 2 for an even one.
- R7: In every remaining case, the numerator is base for a multiplier of 16 and base × mul for any other multiplier.
- R8: Numerators are formed in 64 bits, the division rounds toward zero, and `freq` is the low 32 bits of the quotient.
- R9: `done` goes high for exactly one cycle, on the 65th rising edge after the edge that accepts `start`, and `freq` is valid in that cycle.
- R10: A `start` that arrives while a computation is in progress is ignored: no extra `done` is produced and the result reflects the operands sampled at the accepted start.
- R11: Immediately after reset, `done` is 0 and `freq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that samples all operands |
| boot_word | input | 32 | Boot configuration word (source fields, bypass bit) |
| src_shift | input | 5 | Bit offset of the 2-bit source field inside boot_word |
| ctrl_word | input | 32 | Divider control word |
| pll_word | input | 32 | Loop control word (mode bits, multiplier) |
| base_bus | input | 32 | Bus input frequency, Hz |
| base_ref | input | 32 | Reference input frequency, Hz |
| base_xtal | input | 32 | Crystal input frequency, Hz |
| base_cpu | input | 32 | CPU input frequency, Hz |
| done | output | 1 | One-cycle pulse when freq is updated |
| freq | output | 32 | Computed output frequency, Hz |

## Verification
The bench aims at mode precedence. The bypass bit is set while the loop control word requests both the shift mode and the half-step mode, and a design that tested the loop bits first would return a shifted or multiplied value. Both multiplier-16 special cases are exercised, as is the odd/even split of the half-step path: an off-by-one in the parity test or in `mul − 1` shows up as a factor of two or an extra step of base. A product that overflows 32 bits is checked to come out truncated rather than saturated or wrapped before division, and the extreme divisor of 1024 is checked as well. A second start during a computation must neither disturb the result nor yield a second `done`. The latency is counted exactly, so a divider that runs one step short or long is reported.

// File: rtl/pllf_pkg.sv
package pllf_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_W  = 64;
    localparam int PRE_W  = 5;
    localparam int POST_W = 5;
    localparam int MUL_W  = 4;
    localparam int DEN_W  = PRE_W + POST_W + 1;
    localparam int MULV_W = MUL_W + 1;

    localparam int PRE_LSB   = 16;
    localparam int POST_LSB  = 0;
    localparam int MUL_LSB   = 12;
    localparam int BYPASS_B  = 5;
    localparam int LOCK_B    = 0;
    localparam int HALF_B_HI = 11;
    localparam int HALF_B_LO = 1;

    typedef enum logic [1:0] {
        SRC_BUS  = 2'd0,
        SRC_REF  = 2'd1,
        SRC_XTAL = 2'd2,
        SRC_CPU  = 2'd3
    } pllf_src_e;

    typedef enum logic [1:0] {
        MODE_BYPASS,
        MODE_SHIFT,
        MODE_HALF,
        MODE_MULT
    } pllf_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [DEN_W-1:0]  divisor;
        logic [MULV_W-1:0] mul;
        pllf_mode_e        mode;
    } pllf_cfg_t;

    localparam logic [MULV_W-1:0] MUL_TOP = MULV_W'(1 << MUL_W);

    function automatic logic [NUM_W-1:0] pllf_numerator(pllf_cfg_t cfg);
        logic [NUM_W-1:0] b;
        logic [NUM_W-1:0] m;
        logic [NUM_W-1:0] n;
        b = NUM_W'(cfg.base);
        m = NUM_W'(cfg.mul);
        case (cfg.mode)
            MODE_BYPASS: n = b;
            MODE_SHIFT:  n = (cfg.mul == MUL_TOP) ? (b >> 2) : (b >> 1);
            MODE_HALF:   n = cfg.mul[0] ? ((b * m) >> 1) : ((b * (m - 1)) >> 2);
            default:     n = (cfg.mul == MUL_TOP) ? b : (b * m);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pllf_decode.sv
module pllf_decode
    import pllf_pkg::*;
(
    input  logic [WORD_W-1:0] boot_word,
    input  logic [4:0]        src_shift,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] pll_word,
    input  logic [WORD_W-1:0] base_bus,
    input  logic [WORD_W-1:0] base_ref,
    input  logic [WORD_W-1:0] base_xtal,
    input  logic [WORD_W-1:0] base_cpu,
    output pllf_cfg_t         cfg
);
    logic [WORD_W-1:0] shifted;
    pllf_src_e         src;
    logic [DEN_W-1:0]  pre_v;
    logic [DEN_W-1:0]  post_v;

    always_comb begin
        shifted = boot_word >> src_shift;
        src     = pllf_src_e'(shifted[1:0]);
        case (src)
            SRC_BUS:  cfg.base = base_bus;
            SRC_REF:  cfg.base = base_ref;
            SRC_XTAL: cfg.base = base_xtal;
            default:  cfg.base = base_cpu;
        endcase

        pre_v  = DEN_W'(ctrl_word[PRE_LSB  +: PRE_W])  + DEN_W'(1);
        post_v = DEN_W'(ctrl_word[POST_LSB +: POST_W]) + DEN_W'(1);
        cfg.divisor = pre_v * post_v;

        cfg.mul = MULV_W'(pll_word[MUL_LSB +: MUL_W]) + MULV_W'(1);

        if (boot_word[BYPASS_B])
            cfg.mode = MODE_BYPASS;
        else if (!pll_word[LOCK_B])
            cfg.mode = MODE_SHIFT;
        else if (pll_word[HALF_B_HI] && pll_word[HALF_B_LO])
            cfg.mode = MODE_HALF;
        else
            cfg.mode = MODE_MULT;
    end
endmodule

// File: rtl/pllf_divider.sv
module pllf_divider #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_q;
    logic [DEN_W-1:0] d_q;
    logic [DEN_W:0]   r_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   r_sh;
    logic             fits;

    always_comb begin
        r_sh = {r_q[DEN_W-1:0], q_q[NUM_W-1]};
        fits = (r_sh >= {1'b0, d_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= '0;
            d_q    <= DEN_W'(1);
            r_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                q_q    <= numer;
                d_q    <= denom;
                r_q    <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                q_q   <= {q_q[NUM_W-2:0], fits};
                r_q   <= fits ? (r_sh - {1'b0, d_q}) : r_sh;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = q_q;

    // R10: the controller never reloads a divider that is still working
    assert_no_reload_R10: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q);

    // R8: the partial remainder stays below the divisor at every step
    assert_rem_bound_R8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (r_q < {1'b0, d_q}));

    // R9: completion only follows a working cycle
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q));
endmodule

// File: rtl/pll_freq_decoder.sv
module pll_freq_decoder
    import pllf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] boot_word,
    input  logic [4:0]  src_shift,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] pll_word,
    input  logic [31:0] base_bus,
    input  logic [31:0] base_ref,
    input  logic [31:0] base_xtal,
    input  logic [31:0] base_cpu,
    output logic        done,
    output logic [31:0] freq
);
    pllf_cfg_t        cfg;
    logic [NUM_W-1:0] numer;
    logic             running_q;
    logic             accept;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] div_quot;
    logic             done_q;
    logic [31:0]      freq_q;

    pllf_decode u_decode (
        .boot_word (boot_word),
        .src_shift (src_shift),
        .ctrl_word (ctrl_word),
        .pll_word  (pll_word),
        .base_bus  (base_bus),
        .base_ref  (base_ref),
        .base_xtal (base_xtal),
        .base_cpu  (base_cpu),
        .cfg       (cfg)
    );

    always_comb begin
        numer  = pllf_numerator(cfg);
        accept = start && !running_q;
    end

    pllf_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .numer (numer),
        .denom (cfg.divisor),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            done_q    <= 1'b0;
            freq_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept)
                running_q <= 1'b1;
            if (div_done) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
                freq_q    <= div_quot[31:0];
            end
        end
    end

    assign done = done_q;
    assign freq = freq_q;

    // R9: a single-cycle completion pulse
    assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: the result register only moves on a completion
    assert_freq_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(div_done) |-> $stable(freq_q));

    // R10: while a computation runs, the divider stays busy or is finishing
    assert_running_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (running_q && !div_done) |-> div_busy);
endmodule

// File: tb/sim_pll_freq_decoder.sv
module sim_pll_freq_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] boot_word = '0;
    logic [4:0]  src_shift = '0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] pll_word = '0;
    logic [31:0] base_bus  = 32'd125_000_000;
    logic [31:0] base_ref  = 32'd25_000_000;
    logic [31:0] base_xtal = 32'd24_000_000;
    logic [31:0] base_cpu  = 32'd150_000_000;
    logic        done;
    logic [31:0] freq;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_freq_decoder u0 (
        .clk(clk), .rst(rst), .start(start), .boot_word(boot_word),
        .src_shift(src_shift), .ctrl_word(ctrl_word), .pll_word(pll_word),
        .base_bus(base_bus), .base_ref(base_ref), .base_xtal(base_xtal),
        .base_cpu(base_cpu), .done(done), .freq(freq)
    );

    localparam int LAT = 66; // negedges from the start-driving negedge to done

    function automatic logic [31:0] model(logic [31:0] bw, int sh,
                                          logic [31:0] cw, logic [31:0] pw);
        longint unsigned b, d, m, n;
        int code;
        code = int'((bw >> sh) & 32'd3);
        b = (code == 0) ? base_bus : (code == 1) ? base_ref :
            (code == 2) ? base_xtal : base_cpu;
        d = longint'((cw >> 16) & 32'h1f) + 1;
        d = d * (longint'(cw & 32'h1f) + 1);
        m = longint'((pw >> 12) & 32'hf) + 1;
        if (bw[5])                    n = b;
        else if (!pw[0])              n = (m == 16) ? (b >> 2) : (b >> 1);
        else if (pw[11] && pw[1])     n = (m % 2 == 1) ? ((b * m) >> 1) : ((b * (m - 1)) >> 2);
        else                          n = (m == 16) ? b : (b * m);
        return 32'(n / d);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    // drive one computation, check latency, result and single pulse
    task automatic run_case(string req, logic [31:0] bw, int sh,
                            logic [31:0] cw, logic [31:0] pw, logic [31:0] exp);
        int cyc;
        @(negedge clk);
        boot_word = bw; src_shift = 5'(sh); ctrl_word = cw; pll_word = pw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " R9 latency"}, 32'(cyc), 32'(LAT));
        check(req, freq, exp);
        @(negedge clk);
        check({req, " R9 pulse width"}, 32'(done), 32'd0);
    endtask

    localparam logic [31:0] NORM = 32'h0000_0001; // pll bit0 set, no half bits
    localparam logic [31:0] HALF = 32'h0000_0803;

    task automatic t_reset;
        check("R11 done after reset", 32'(done), 32'd0);
        check("R11 freq after reset", freq, 32'd0);
    endtask

    task automatic t_source;
        for (int c = 0; c < 4; c++) begin
            logic [31:0] bw;
            bw = 32'(c) << 14;
            run_case("R1 source select", bw, 14, 32'd0, NORM, model(bw, 14, 32'd0, NORM));
        end
        run_case("R1 source at shift 22", 32'h0080_C000, 22, 32'd0, NORM, base_xtal);
        run_case("R1 source at shift 16", 32'h0003_0000, 16, 32'd0, NORM, base_cpu);
    endtask

    task automatic t_divisor;
        run_case("R2 divisor 4x5", 32'h20, 0, 32'h0003_0004, NORM, 32'd125_000_000 / 20);
        run_case("R2 divisor 1024", 32'h20, 0, 32'h001F_001F, NORM, 32'd125_000_000 / 1024);
    endtask

    task automatic t_mul;
        run_case("R3 mul 5", 32'd0, 0, 32'd0, 32'h0000_4001, 32'd625_000_000);
        run_case("R3 mul 2 prediv 5", 32'h4000, 14, 32'h0004_0000, 32'h0000_1001, 32'd10_000_000);
    endtask

    task automatic t_bypass;
        run_case("R4 bypass over shift", 32'h20, 0, 32'h0000_0002, 32'h0000_F800, 32'd125_000_000 / 3);
        run_case("R4 bypass over half", 32'h20, 0, 32'd0, 32'h0000_6803, 32'd125_000_000);
    endtask

    task automatic t_shift;
        run_case("R5 shift mul 3", 32'd0, 0, 32'd0, 32'h0000_2000, 32'd62_500_000);
        run_case("R5 shift mul 16", 32'd0, 0, 32'h0000_0001, 32'h0000_F000, 32'd125_000_000 / 4 / 2);
        run_case("R5 shift ignores half bits", 32'd0, 0, 32'd0, 32'h0000_0802, 32'd62_500_000);
    endtask

    task automatic t_half;
        run_case("R6 half odd mul 7", 32'd0, 0, 32'd0, HALF | 32'h6000, 32'd437_500_000);
        run_case("R6 half even mul 8", 32'd0, 0, 32'd0, HALF | 32'h7000, 32'd218_750_000);
        run_case("R6 half even mul 2", 32'h4000, 14, 32'd0, HALF | 32'h1000, 32'd6_250_000);
        run_case("R6 only bit11 is normal", 32'h4000, 14, 32'd0, 32'h0000_6801, 32'd175_000_000);
    endtask

    task automatic t_mult;
        run_case("R7 mul 16 passes base", 32'd0, 0, 32'h0001_0000, 32'h0000_F001, 32'd62_500_000);
        run_case("R7 mul 15", 32'h4000, 14, 32'h0000_0002, 32'h0000_E001, 32'd125_000_000);
    endtask

    task automatic t_width;
        logic [31:0] saved;
        saved = base_cpu;
        base_cpu = 32'h2000_0000;
        run_case("R8 truncated product", 32'h0000_C000, 14, 32'd0, 32'h0000_E001, 32'hE000_0000);
        run_case("R8 wide product then divide", 32'h0000_C000, 14, 32'h0000_0003, 32'h0000_E001, 32'h7800_0000);
        base_cpu = 32'd25_000_001;
        run_case("R8 floor division", 32'h0000_C000, 14, 32'h0000_0002, NORM, 32'd8_333_333);
        base_cpu = saved;
    endtask

    task automatic t_busy;
        int cyc;
        int extra;
        @(negedge clk);
        boot_word = 32'd0; src_shift = 5'd0; ctrl_word = 32'd0; pll_word = 32'h0000_1001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (4) begin @(negedge clk); cyc++; end
        pll_word = 32'h0000_3001; ctrl_word = 32'h0000_0007; start = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        check("R10 latency unchanged by second start", 32'(cyc), 32'(LAT));
        check("R10 result from first operands", freq, 32'd250_000_000);
        extra = 0;
        repeat (80) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R10 no second done", 32'(extra), 32'd0);
        check("R10 result held", freq, 32'd250_000_000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_source();
        t_divisor();
        t_mul();
        t_bypass();
        t_shift();
        t_half();
        t_mult();
        t_width();
        t_busy();
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150_000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule